// File: doc/BRIEF.md
# Keyed Return-Address Hash Store and Check Controller

This controller carries out the four fixed-point hash instructions of a 64-bit core: a plain and a privileged hash-store, and a plain and a privileged hash-check. It takes an instruction word together with the two source register values, the current privilege state, a flag that says whether the core implements the architecture level that defines these instructions, and the two 64-bit hash keys. It decodes the word and forms a negative, doubleword-aligned effective address below the base register. It then asks an external digest engine to hash the two register values under the selected key.

A store form writes the returned 64-bit digest to memory. A check form reads the doubleword at the same address and raises a trap when it differs from the digest. This lets software detect a corrupted saved return address. Fault checks are done in one decode cycle before any request leaves the block. The digest engine and the memory system both sit behind simple valid/ready ports.

Top module: `hash_guard_ctrl`

## Requirements
- R1: An instruction is a hash instruction only when bits 31:26 equal 011111 and bits 10:1 equal one of four codes: 1011010010 (store), 1011110010 (check), 1010010010 (privileged store), 1010110010 (privileged check).
- R2: The effective address is RA plus a displacement whose bits 8:3 hold the 6-bit index {instr[0], instr[25:21]}, whose bits 2:0 are zero and whose bits 63:9 are one. This spans -512 (index 0) to -8 (index 63).
- R3: The digest request carries RA as its first operand and RB as its second. Its key is the user key for the plain forms and the privileged key for the privileged forms.
- R4: A store form issues one memory write of the returned digest to the effective address and then completes.
- R5: A check form issues one memory read at the effective address. It pulses `trap` for one cycle only when the returned data differs from the digest.
- R6: A privileged form issued with `user_mode`=1 pulses `priv_fault` for one cycle and makes no digest or memory request.
- R7: A hash instruction whose RA field (bits 20:16) is zero pulses `illegal_fault` for one cycle and makes no digest or memory request.
- R8: When `isa_ok`=0, every hash instruction completes with no request and no fault.
- R9: Fault checks are taken in this order: level no-op, then privilege, then RA=0. At most one of `trap`, `priv_fault` and `illegal_fault` is high in any cycle.
- R10: A word accepted while idle that is not a hash instruction is dropped. Busy does not rise and no output changes.
- R11: `busy` rises the cycle after a hash instruction is accepted. It falls when the store write is accepted, when the check data is compared, or when the decode stage ends the instruction. `in_ready` is low while busy, and words offered then are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Controller can accept a word |
| instr | input | 32 | Instruction word |
| ra_val | input | 64 | Base register value |
| rb_val | input | 64 | Second register value |
| user_mode | input | 1 | 1 = problem (user) state |
| isa_ok | input | 1 | 1 = hash instructions are implemented |
| key_user | input | 64 | Key for the plain forms |
| key_priv | input | 64 | Key for the privileged forms |
| dg_req_valid | output | 1 | Digest request valid |
| dg_req_ready | input | 1 | Digest engine accepts request |
| dg_a | output | 64 | Digest first operand (RA) |
| dg_b | output | 64 | Digest second operand (RB) |
| dg_key | output | 64 | Selected key |
| dg_rsp_valid | input | 1 | Digest result valid |
| dg_rsp_data | input | 64 | Digest result |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Effective address |
| mem_wdata | output | 64 | Digest to store |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 64 | Read data |
| busy | output | 1 | Instruction in flight |
| trap | output | 1 | Check mismatch pulse |
| priv_fault | output | 1 | Privileged-operation fault pulse |
| illegal_fault | output | 1 | Illegal-form fault pulse |

## Verification
Some properties are checked on every cycle. The three outcome pulses are mutually exclusive. A fault never coincides with a digest or memory request. Requests hold their operands while they stall. A trap only follows returned read data, and busy only starts after an accepted word. The scenarios are needed for the rest: the exact address for the extreme index values, the choice of key, the written digest value, the trap decision on match and mismatch, and which single fault wins when several conditions hold together. Those outcomes depend on data values that only a reference computed in the bench can predict.

// File: rtl/hg_pkg.sv
package hg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_DEC, ST_DREQ, ST_DWAIT, ST_MREQ, ST_MWAIT
   } hg_state_e;

   localparam logic [5:0] PRIMARY_OP = 6'b011111;
   localparam int NFORMS = 4;
   // table index: 0 store, 1 check, 2 privileged store, 3 privileged check
   localparam logic [9:0] XO_CODE [NFORMS] = '{
      10'b1011010010, 10'b1011110010, 10'b1010010010, 10'b1010110010
   };
   localparam logic [NFORMS-1:0] FORM_IS_STORE = 4'b0101;
   localparam logic [NFORMS-1:0] FORM_IS_PRIV  = 4'b1100;
endpackage

// File: rtl/hg_decode.sv
module hg_decode
   import hg_pkg::*;
#(
   parameter int IDXW = 6
) (
   input  logic [31:0]     instr,
   output logic            hit,
   output logic            is_store,
   output logic            is_priv,
   output logic            ra_zero,
   output logic [IDXW-1:0] idx
);
   logic [NFORMS-1:0] match;

   // R1: one comparator per table entry
   for (genvar g = 0; g < NFORMS; g++) begin : g_form
      assign match[g] = (instr[31:26] == PRIMARY_OP) && (instr[10:1] == XO_CODE[g]);
   end

   assign hit      = |match;
   assign is_store = |(match & FORM_IS_STORE);
   assign is_priv  = |(match & FORM_IS_PRIV);
   assign ra_zero  = (instr[20:16] == 5'd0);
   assign idx      = {instr[0], instr[25:21]};
endmodule

// File: rtl/hg_agen.sv
module hg_agen #(
   parameter int XLEN     = 64,
   parameter int IDXW     = 6,
   parameter int SCALE_LG = 3
) (
   input  logic [XLEN-1:0] base,
   input  logic [IDXW-1:0] idx,
   output logic [XLEN-1:0] ea
);
   localparam int TOPW = IDXW + SCALE_LG;

   if (XLEN <= TOPW) begin : g_bad_width
      $error("hg_agen: XLEN too small for displacement");
   end

   logic [XLEN-1:0] disp;
   // R2: all-ones above the scaled index, zero below it
   assign disp = {{(XLEN-TOPW){1'b1}}, idx, {SCALE_LG{1'b0}}};
   assign ea   = base + disp;
endmodule

// File: rtl/hash_guard_ctrl.sv
module hash_guard_ctrl
   import hg_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int IDXW   = 6,
   parameter bit EA_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [31:0]     instr,
   input  logic [XLEN-1:0] ra_val,
   input  logic [XLEN-1:0] rb_val,
   input  logic            user_mode,
   input  logic            isa_ok,
   input  logic [XLEN-1:0] key_user,
   input  logic [XLEN-1:0] key_priv,
   output logic            dg_req_valid,
   input  logic            dg_req_ready,
   output logic [XLEN-1:0] dg_a,
   output logic [XLEN-1:0] dg_b,
   output logic [XLEN-1:0] dg_key,
   input  logic            dg_rsp_valid,
   input  logic [XLEN-1:0] dg_rsp_data,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic            mem_req_write,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   input  logic            mem_rsp_valid,
   input  logic [XLEN-1:0] mem_rsp_rdata,
   output logic            busy,
   output logic            trap,
   output logic            priv_fault,
   output logic            illegal_fault
);
   if (XLEN < 16) begin : g_bad_xlen
      $error("hash_guard_ctrl: XLEN must be at least 16");
   end
   if (IDXW != 6) begin : g_bad_idx
      $error("hash_guard_ctrl: index width is fixed by the encoding");
   end

   hg_state_e       state;
   logic            dec_hit, dec_store, dec_priv, dec_ra0;
   logic [IDXW-1:0] dec_idx;
   logic            store_q, priv_q, ra0_q, user_q, isa_q;
   logic [IDXW-1:0] idx_q;
   logic [XLEN-1:0] ra_q, rb_q, digest_q, ea;
   logic            accept;

   hg_decode #(.IDXW(IDXW)) dec_i (
      .instr(instr), .hit(dec_hit), .is_store(dec_store),
      .is_priv(dec_priv), .ra_zero(dec_ra0), .idx(dec_idx)
   );

   // R2: address either captured at accept or formed from held operands
   if (EA_REG) begin : g_ea_reg
      logic [XLEN-1:0] ea_next, ea_q;
      hg_agen #(.XLEN(XLEN), .IDXW(IDXW)) agen_i (
         .base(ra_val), .idx(dec_idx), .ea(ea_next));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      ea_q <= '0;
         else if (accept) ea_q <= ea_next;
      end
      assign ea = ea_q;
   end else begin : g_ea_comb
      hg_agen #(.XLEN(XLEN), .IDXW(IDXW)) agen_i (
         .base(ra_q), .idx(idx_q), .ea(ea));
   end

   assign in_ready = (state == ST_IDLE);
   assign accept   = in_valid && in_ready && dec_hit;
   assign busy     = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         store_q       <= 1'b0;
         priv_q        <= 1'b0;
         ra0_q         <= 1'b0;
         user_q        <= 1'b0;
         isa_q         <= 1'b0;
         idx_q         <= '0;
         ra_q          <= '0;
         rb_q          <= '0;
         digest_q      <= '0;
         trap          <= 1'b0;
         priv_fault    <= 1'b0;
         illegal_fault <= 1'b0;
      end else begin
         trap          <= 1'b0;
         priv_fault    <= 1'b0;
         illegal_fault <= 1'b0;
         case (state)
            ST_IDLE: if (accept) begin
               store_q <= dec_store;
               priv_q  <= dec_priv;
               ra0_q   <= dec_ra0;
               user_q  <= user_mode;
               isa_q   <= isa_ok;
               idx_q   <= dec_idx;
               ra_q    <= ra_val;
               rb_q    <= rb_val;
               state   <= ST_DEC;
            end
            ST_DEC: begin
               // R9: level no-op, then privilege, then RA=0
               if (!isa_q) begin
                  state <= ST_IDLE;
               end else if (priv_q && user_q) begin
                  priv_fault <= 1'b1;
                  state      <= ST_IDLE;
               end else if (ra0_q) begin
                  illegal_fault <= 1'b1;
                  state         <= ST_IDLE;
               end else begin
                  state <= ST_DREQ;
               end
            end
            ST_DREQ:  if (dg_req_ready) state <= ST_DWAIT;
            ST_DWAIT: if (dg_rsp_valid) begin
               digest_q <= dg_rsp_data;
               state    <= ST_MREQ;
            end
            ST_MREQ:  if (mem_req_ready) state <= store_q ? ST_IDLE : ST_MWAIT;
            ST_MWAIT: if (mem_rsp_valid) begin
               trap  <= (mem_rsp_rdata != digest_q);
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign dg_req_valid  = (state == ST_DREQ);
   assign dg_a          = ra_q;
   assign dg_b          = rb_q;
   assign dg_key        = priv_q ? key_priv : key_user;
   assign mem_req_valid = (state == ST_MREQ);
   assign mem_req_write = store_q;
   assign mem_addr      = ea;
   assign mem_wdata     = digest_q;

   assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({trap, priv_fault, illegal_fault}));
   assert_fault_no_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_fault || illegal_fault) |-> (!dg_req_valid && !mem_req_valid));
   assert_dg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dg_req_valid && !dg_req_ready) |=> (dg_req_valid && $stable(dg_a) && $stable(dg_b)));
   assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr) && $stable(mem_wdata)));
   assert_trap_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> $past(mem_rsp_valid));
   assert_busy_from_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(in_valid && in_ready));
endmodule

// File: tb/hash_guard_ctrl_tb_top.sv
module hash_guard_ctrl_tb_top;
   localparam logic [9:0] XO_ST  = 10'b1011010010;
   localparam logic [9:0] XO_CK  = 10'b1011110010;
   localparam logic [9:0] XO_PST = 10'b1010010010;
   localparam logic [9:0] XO_PCK = 10'b1010110010;
   localparam int EV_WR = 0, EV_RD = 1, EV_TRAP = 2, EV_PRIV = 3, EV_ILL = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   logic in_valid = 0, in_ready, user_mode = 0, isa_ok = 1;
   logic [31:0] instr = '0;
   logic [63:0] ra_val = '0, rb_val = '0;
   logic [63:0] key_user = 64'h0123_4567_89AB_CDEF, key_priv = 64'hF00D_CAFE_1357_9BDF;
   logic dg_req_valid, dg_req_ready = 1, dg_rsp_valid = 0;
   logic [63:0] dg_a, dg_b, dg_key, dg_rsp_data = '0;
   logic mem_req_valid, mem_req_ready = 1, mem_req_write, mem_rsp_valid = 0;
   logic [63:0] mem_addr, mem_wdata, mem_rsp_rdata = '0;
   logic busy, trap, priv_fault, illegal_fault;

   hash_guard_ctrl dut_i (.*);

   typedef struct packed { logic [2:0] kind; logic [63:0] addr; logic [63:0] data; } ev_t;
   ev_t   exp_q[$];
   string tag_q[$];
   logic [63:0] mem [logic [63:0]];
   int checks = 0, errors = 0;
   bit done = 0;

   function automatic logic [63:0] ref_dg(logic [63:0] a, logic [63:0] b, logic [63:0] k);
      return a ^ {b[31:0], b[63:32]} ^ {k[62:0], k[63]};
   endfunction
   function automatic logic [31:0] mk(logic [9:0] xo, logic [4:0] ra, logic [5:0] idx);
      return {6'b011111, idx[4:0], ra, 5'd3, xo, idx[5]};
   endfunction
   function automatic logic [63:0] ea_of(logic [63:0] ra, logic [5:0] idx);
      return ra + {55'h7F_FFFF_FFFF_FFFF, idx, 3'b000};
   endfunction

   task automatic expect_ev(int kind, logic [63:0] a, logic [63:0] d, string tag);
      ev_t e;
      e.kind = kind[2:0]; e.addr = a; e.data = d;
      exp_q.push_back(e); tag_q.push_back(tag);
   endtask

   task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic observe(int kind, logic [63:0] a, logic [63:0] d);
      ev_t e; string t;
      if (exp_q.size() == 0) begin
         chk(0, "R6/R7/R8/R10", "unexpected event kind", 64'(kind), 64'hFF);
      end else begin
         e = exp_q.pop_front(); t = tag_q.pop_front();
         chk(e.kind == kind[2:0], t, "event kind", 64'(kind), 64'(e.kind));
         chk(e.addr == a, t, "address", a, e.addr);
         chk(e.data == d, t, "data", d, e.data);
      end
   endtask

   // digest engine model
   initial begin
      bit pend = 0; logic [63:0] val = '0;
      forever begin
         @(negedge clk);
         dg_rsp_valid = 0;
         if (pend) begin dg_rsp_valid = 1; dg_rsp_data = val; pend = 0; end
         if (dg_req_valid && dg_req_ready) begin pend = 1; val = ref_dg(dg_a, dg_b, dg_key); end
      end
   end

   // memory model and monitor
   initial begin
      bit pend = 0; logic [63:0] rd = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 0;
         if (pend) begin mem_rsp_valid = 1; mem_rsp_rdata = rd; pend = 0; end
         if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
               mem[mem_addr] = mem_wdata;
               observe(EV_WR, mem_addr, mem_wdata);
            end else begin
               rd = mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
               pend = 1;
               observe(EV_RD, mem_addr, 64'h0);
            end
         end
         if (trap)          observe(EV_TRAP, 0, 0);
         if (priv_fault)    observe(EV_PRIV, 0, 0);
         if (illegal_fault) observe(EV_ILL, 0, 0);
      end
   end

   task automatic run(logic [31:0] w, logic [63:0] ra, logic [63:0] rb, bit um, bit ok,
                      bit want_busy, string tag);
      @(negedge clk);
      instr = w; ra_val = ra; rb_val = rb; user_mode = um; isa_ok = ok; in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      chk(busy == want_busy, tag, "busy after accept", 64'(busy), 64'(want_busy));
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, tag, "missing expected events", 64'(exp_q.size()), 0);
      exp_q.delete(); tag_q.delete();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] ra, rb, a;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      chk(busy == 0 && in_ready == 1, "R11", "reset busy/ready", {busy, in_ready}, 2'b01);
      chk({trap, priv_fault, illegal_fault, mem_req_valid, dg_req_valid} == 0, "R9",
          "reset outputs", {trap, priv_fault, illegal_fault, mem_req_valid, dg_req_valid}, 0);

      // R4/R2 store, index 0 -> -512, user key (R3)
      ra = 64'h0000_1000_0000_4000; rb = 64'hDEAD_BEEF_0BAD_F00D;
      expect_ev(EV_WR, ra - 512, ref_dg(ra, rb, key_user), "R4");
      run(mk(XO_ST, 5'd1, 6'd0), ra, rb, 1, 1, 1, "R4");

      // R2 index 63 -> -8, odd base
      ra = 64'h0000_0000_0000_0003; rb = 64'h1111_2222_3333_4444;
      expect_ev(EV_WR, ra - 8, ref_dg(ra, rb, key_user), "R2");
      run(mk(XO_ST, 5'd5, 6'd63), ra, rb, 0, 1, 1, "R2");

      // R3 privileged store uses privileged key
      ra = 64'h0000_0000_8000_0000; rb = 64'h0F0F_0F0F_F0F0_F0F0;
      expect_ev(EV_WR, ea_of(ra, 6'd33), ref_dg(ra, rb, key_priv), "R3");
      run(mk(XO_PST, 5'd31, 6'd33), ra, rb, 0, 1, 1, "R3");
      chk(ea_of(ra, 6'd33) == ra - 512 + 33*8, "R2", "bench address model",
          ea_of(ra, 6'd33), ra - 512 + 33*8);

      // R5 check, matching data: read only, no trap
      ra = 64'h0000_2000_0000_0100; rb = 64'hAAAA_5555_AAAA_5555;
      a = ea_of(ra, 6'd10); mem[a] = ref_dg(ra, rb, key_user);
      expect_ev(EV_RD, a, 0, "R5");
      run(mk(XO_CK, 5'd2, 6'd10), ra, rb, 1, 1, 1, "R5");

      // R5 check, mismatch: read then trap
      mem[a] = ref_dg(ra, rb, key_user) ^ 64'h1;
      expect_ev(EV_RD, a, 0, "R5");
      expect_ev(EV_TRAP, 0, 0, "R5");
      run(mk(XO_CK, 5'd2, 6'd10), ra, rb, 1, 1, 1, "R5");

      // R3/R5 privileged check in supervisor, data stored with privileged key
      a = ea_of(ra, 6'd40); mem[a] = ref_dg(ra, rb, key_priv);
      expect_ev(EV_RD, a, 0, "R3");
      run(mk(XO_PCK, 5'd2, 6'd40), ra, rb, 0, 1, 1, "R3");

      // R6 privileged check from user state
      expect_ev(EV_PRIV, 0, 0, "R6");
      run(mk(XO_PCK, 5'd2, 6'd7), ra, rb, 1, 1, 1, "R6");

      // R7 RA field zero
      expect_ev(EV_ILL, 0, 0, "R7");
      run(mk(XO_ST, 5'd0, 6'd7), ra, rb, 1, 1, 1, "R7");

      // R8 old level: no-op even for a check
      run(mk(XO_CK, 5'd2, 6'd10), ra, rb, 1, 0, 1, "R8");

      // R9 priority: old level beats privilege and RA=0
      run(mk(XO_PST, 5'd0, 6'd1), ra, rb, 1, 0, 1, "R9");
      // R9 priority: privilege beats RA=0
      expect_ev(EV_PRIV, 0, 0, "R9");
      run(mk(XO_PST, 5'd0, 6'd1), ra, rb, 1, 1, 1, "R9");

      // R10 wrong extended opcode and wrong primary opcode
      run({6'b011111, 5'd0, 5'd2, 5'd3, 10'b1011010011, 1'b0}, ra, rb, 1, 1, 0, "R10");
      run({6'b011110, 5'd0, 5'd2, 5'd3, XO_ST, 1'b0}, ra, rb, 1, 1, 0, "R10");

      // R11 words offered while busy are not taken
      ra = 64'h0000_0000_0010_0000; rb = 64'h7;
      expect_ev(EV_WR, ea_of(ra, 6'd5), ref_dg(ra, rb, key_user), "R11");
      @(negedge clk);
      instr = mk(XO_ST, 5'd4, 6'd5); ra_val = ra; rb_val = rb; user_mode = 1; isa_ok = 1;
      in_valid = 1;
      @(negedge clk);
      instr = mk(XO_ST, 5'd4, 6'd9); ra_val = ra + 64'h100;
      chk(busy == 1 && in_ready == 0, "R11", "ready while busy", {busy, in_ready}, 2'b10);
      repeat (2) @(negedge clk);
      in_valid = 0;
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R11", "missing expected events", 64'(exp_q.size()), 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule